// File: doc/BRIEF.md
# Voltage Reference Slew Ramp Generator

This block produces the digital setpoint code that feeds a regulator's reference DAC. Instead of jumping to a new setpoint, the code walks toward the requested goal in fixed steps. A step-enable tick sets the pace. The tick comes from a prescaler that counts system clocks, and its interval is a power-of-two multiple of one fast base interval.

After reset the block loads a boot goal, chosen by a single select input, and ramps up to it from zero at the soft-start pace. Only then does it accept host targets. A host target can arrive at any time, including in the middle of a ramp. It then ramps at one of three paces: fast, soft-start (four times slower), or slow (two, four, eight or sixteen times slower, with a separate select for the divider). A fault request takes priority over everything else. It sends the code down to zero at the slow pace and stays in force until the next reset.

With the default parameters, one code LSB is 5 mV and a step is 2 LSB. The fast interval is 71 cycles of a 100 MHz clock, which gives about 14 mV/µs. The code range is capped at 460, which corresponds to 2.3 V.

Top module: `vid_slew_ramp`

## Requirements
- R1: While `rst` is high, `dac_code` is 0 and the active goal becomes 270 when `boot_sel`=1 or 180 when `boot_sel`=0. After `rst` falls, `boot_sel` has no effect until the next reset.
- R2: After reset, the code ramps from 0 to the boot goal at the soft-start interval of 4×FAST_DIV cycles per step. Host loads (`target_load`) have no effect until the code has reached the boot goal.
- R3: Each step moves the code by STEP_LSB toward the goal. When the remaining distance is at most STEP_LSB, the step lands exactly on the goal, so the code never passes it. The first step happens exactly one interval after the load edge, and the code holds steady in between.
- R4: The interval in cycles is chosen by `slew_sel` and `slow_sel`. `slew_sel` 2'b00 selects fast (FAST_DIV). 2'b10 and 2'b11 select soft-start (4×FAST_DIV). 2'b01 selects slow, with the multiplier from `slow_sel`: 2'b00 gives ×4, 2'b01 gives ×2, 2'b10 gives ×8 and 2'b11 gives ×16.
- R5: A host target above MAX_CODE (460) is clamped to MAX_CODE.
- R6: `settled` is high in every cycle in which `dac_code` equals the active goal. It is low in the cycle after a load or fault request that moves the goal away from the code.
- R7: A load during a ramp redirects the ramp from the current code without returning to zero. The step interval restarts from the load edge.
- R8: A `zero_req` pulse sets the goal to 0, and the code then ramps down at the slow interval selected by `slow_sel`. The request wins over a `target_load` in the same cycle.
- R9: After a `zero_req` has been taken, further `target_load` and `zero_req` pulses have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_sel | input | 1 | Boot goal select, sampled only during reset (1 = 270, 0 = 180) |
| target_code | input | CODE_W | Host setpoint code |
| target_load | input | 1 | One-cycle strobe that takes `target_code` |
| slew_sel | input | 2 | Pace select: fast, slow or soft-start |
| slow_sel | input | 2 | Slow-pace divider select |
| zero_req | input | 1 | Fault request: ramp to zero and lock |
| dac_code | output | CODE_W | Present reference code |
| settled | output | 1 | Code equals the active goal |

## Verification
A host load and a fault request can arrive in the same cycle. In that case the fault must win. The bench provokes this by pulsing `target_load` with code 300 and `zero_req` together while the code sits at 460. It then checks every slow-paced step down to zero, and checks that `settled` drops in the first cycle. The bench also lands a load on a cycle when a step of the previous ramp is due. It judges the result by checking that no step appears at that edge and that the new interval counts from the load edge.

// File: rtl/vid_ramp_pkg.sv
package vid_ramp_pkg;

    typedef enum logic [1:0] {
        PH_BOOT  = 2'd0,
        PH_RUN   = 2'd1,
        PH_FAULT = 2'd2
    } phase_t;

    localparam logic [1:0] PACE_FAST = 2'b00;
    localparam logic [1:0] PACE_SLOW = 2'b01;
    localparam logic [2:0] SOFT_SHIFT = 3'd2;

    // Slow divider select to shift amount: 00 -> x4, 01 -> x2, 10 -> x8, 11 -> x16
    function automatic logic [2:0] slow_shift(input logic [1:0] sel);
        logic [2:0] s;
        case (sel)
            2'b01:   s = 3'd1;
            2'b10:   s = 3'd3;
            2'b11:   s = 3'd4;
            default: s = 3'd2;
        endcase
        return s;
    endfunction

    function automatic logic [2:0] pace_shift(input phase_t ph,
                                              input logic [1:0] pace,
                                              input logic [1:0] sdiv);
        logic [2:0] s;
        if (ph == PH_BOOT)
            s = SOFT_SHIFT;
        else if (ph == PH_FAULT)
            s = slow_shift(sdiv);
        else if (pace == PACE_FAST)
            s = 3'd0;
        else if (pace == PACE_SLOW)
            s = slow_shift(sdiv);
        else
            s = SOFT_SHIFT;
        return s;
    endfunction

endpackage

// File: rtl/vid_rate_timer.sv
module vid_rate_timer #(
    parameter int FAST_DIV = 71
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       active,
    input  logic [2:0] shift,
    output logic       tick
);
    localparam int MAX_IV = FAST_DIV * 16;
    localparam int CW     = $clog2(MAX_IV + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] interval;

    always_comb begin
        interval = CW'(FAST_DIV) << shift;
        tick     = active && !restart && (cnt_q >= interval - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (restart || !active || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/vid_goal_ctrl.sv
module vid_goal_ctrl import vid_ramp_pkg::*; #(
    parameter int CODE_W   = 9,
    parameter int MAX_CODE = 460,
    parameter int BOOT_LO  = 180,
    parameter int BOOT_HI  = 270
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_sel,
    input  logic [CODE_W-1:0] target_code,
    input  logic              target_load,
    input  logic              zero_req,
    input  logic              at_goal,
    output logic [CODE_W-1:0] goal_q,
    output phase_t            phase_q,
    output logic              restart
);
    logic              take_fault;
    logic              take_load;
    logic [CODE_W-1:0] clamped;

    always_comb begin
        take_fault = zero_req && (phase_q != PH_FAULT);
        take_load  = target_load && (phase_q == PH_RUN) && !take_fault;
        restart    = take_fault || take_load;
        clamped    = (target_code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : target_code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_BOOT;
            goal_q  <= boot_sel ? CODE_W'(BOOT_HI) : CODE_W'(BOOT_LO);
        end else if (take_fault) begin
            phase_q <= PH_FAULT;
            goal_q  <= '0;
        end else begin
            case (phase_q)
                PH_BOOT: if (at_goal) phase_q <= PH_RUN;
                PH_RUN:  if (take_load) goal_q <= clamped;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vid_code_stepper.sv
module vid_code_stepper #(
    parameter int CODE_W   = 9,
    parameter int STEP_LSB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CODE_W-1:0] goal,
    output logic [CODE_W-1:0] code_q
);
    localparam logic [CODE_W-1:0] STEP = CODE_W'(STEP_LSB);

    logic [CODE_W-1:0] nxt;

    always_comb begin
        if (goal > code_q)
            nxt = ((goal - code_q) <= STEP) ? goal : code_q + STEP;
        else if (goal < code_q)
            nxt = ((code_q - goal) <= STEP) ? goal : code_q - STEP;
        else
            nxt = code_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (tick)
            code_q <= nxt;
    end
endmodule

// File: rtl/vid_slew_ramp.sv
module vid_slew_ramp import vid_ramp_pkg::*; #(
    parameter int CODE_W   = 9,
    parameter int MAX_CODE = 460,
    parameter int STEP_LSB = 2,
    parameter int FAST_DIV = 71,
    parameter int BOOT_LO  = 180,
    parameter int BOOT_HI  = 270
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_sel,
    input  logic [CODE_W-1:0] target_code,
    input  logic              target_load,
    input  logic [1:0]        slew_sel,
    input  logic [1:0]        slow_sel,
    input  logic              zero_req,
    output logic [CODE_W-1:0] dac_code,
    output logic              settled
);
    logic [CODE_W-1:0] goal_q;
    phase_t            phase_q;
    logic              restart;
    logic              step_tick;
    logic              at_goal;
    logic [2:0]        shift;

    always_comb begin
        at_goal = (dac_code == goal_q);
        shift   = pace_shift(phase_q, slew_sel, slow_sel);
    end

    assign settled = at_goal;

    vid_goal_ctrl #(
        .CODE_W(CODE_W), .MAX_CODE(MAX_CODE),
        .BOOT_LO(BOOT_LO), .BOOT_HI(BOOT_HI)
    ) u_goal (
        .clk(clk), .rst(rst), .boot_sel(boot_sel),
        .target_code(target_code), .target_load(target_load),
        .zero_req(zero_req), .at_goal(at_goal),
        .goal_q(goal_q), .phase_q(phase_q), .restart(restart)
    );

    vid_rate_timer #(.FAST_DIV(FAST_DIV)) u_timer (
        .clk(clk), .rst(rst), .restart(restart),
        .active(!at_goal), .shift(shift), .tick(step_tick)
    );

    vid_code_stepper #(.CODE_W(CODE_W), .STEP_LSB(STEP_LSB)) u_step (
        .clk(clk), .rst(rst), .tick(step_tick),
        .goal(goal_q), .code_q(dac_code)
    );
endmodule

// File: rtl/vid_slew_ramp_chk.sv
module vid_slew_ramp_chk import vid_ramp_pkg::*; #(
    parameter int CODE_W   = 9,
    parameter int MAX_CODE = 460,
    parameter int STEP_LSB = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              zero_req,
    input logic [CODE_W-1:0] dac_code,
    input logic [CODE_W-1:0] goal,
    input logic              tick,
    input phase_t            phase
);
    // R3
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        (((dac_code >= $past(dac_code)) ? (dac_code - $past(dac_code))
                                        : ($past(dac_code) - dac_code)) <= CODE_W'(STEP_LSB)));

    // R3
    no_overshoot_up_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_code < goal) |=> (dac_code <= $past(goal)));

    // R3
    no_overshoot_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_code > goal) |=> (dac_code >= $past(goal)));

    // R4
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(dac_code));

    // R5
    code_cap_chk: assert property (@(posedge clk) disable iff (rst)
        dac_code <= CODE_W'(MAX_CODE));

    // R8
    fault_descend_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FAULT) |=> (dac_code <= $past(dac_code)));

    // R2
    boot_goal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BOOT && !zero_req) |=> $stable(goal));
endmodule

bind vid_slew_ramp vid_slew_ramp_chk #(
    .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .STEP_LSB(STEP_LSB)
) u_chk (
    .clk(clk), .rst(rst), .zero_req(zero_req), .dac_code(dac_code),
    .goal(goal_q), .tick(step_tick), .phase(phase_q)
);

// File: tb/vid_slew_ramp_test.sv
module vid_slew_ramp_test;
    localparam int STEP = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       boot_sel = 1'b1;
    logic [8:0] target_code = '0;
    logic       target_load = 1'b0;
    logic [1:0] slew_sel = 2'b00;
    logic [1:0] slow_sel = 2'b00;
    logic       zero_req = 1'b0;
    logic [8:0] dac_code;
    logic       settled;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        int    cy;
        int    code;
        bit    stl;
        string tag;
    } exp_t;

    exp_t sb[$];
    exp_t e;

    vid_slew_ramp #(.FAST_DIV(4)) uut (
        .clk(clk), .rst(rst), .boot_sel(boot_sel), .target_code(target_code),
        .target_load(target_load), .slew_sel(slew_sel), .slow_sel(slow_sel),
        .zero_req(zero_req), .dac_code(dac_code), .settled(settled)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expected items as their cycle comes up
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cy <= cyc) begin
            e = sb.pop_front();
            checks++;
            if (e.cy != cyc || dac_code !== 9'(e.code) || settled !== e.stl) begin
                fails++;
                $display("FAIL %s: cycle %0d code=%0d settled=%0b, expected cycle %0d code=%0d settled=%0b",
                         e.tag, cyc, dac_code, settled, e.cy, e.code, e.stl);
            end
        end
    end

    task automatic push(input int cy, input int code, input bit stl, input string tag);
        exp_t x;
        x.cy = cy; x.code = code; x.stl = stl; x.tag = tag;
        sb.push_back(x);
    endtask

    // Driver model: expected trajectory from the requirements
    task automatic plan(input int from, input int goal, input int iv, input int c0,
                        input int max_steps, input bit chk0, input string tag,
                        output int last, output int endc);
        int c = from;
        int k = 0;
        if (chk0) push(c0, from, from == goal, {tag, " R6"});
        if (iv > 1) push(c0 + iv - 1, from, from == goal, tag);
        while (c != goal && k < max_steps) begin
            k++;
            if (goal > c) c = (goal - c <= STEP) ? goal : c + STEP;
            else          c = (c - goal <= STEP) ? goal : c - STEP;
            push(c0 + k * iv, c, c == goal, tag);
        end
        last = c;
        endc = c0 + k * iv + 2;
    endtask

    task automatic go(input int t, input bit z, input int from, input int goal,
                      input int iv, input int max_steps, input string tag,
                      output int last, output int endc);
        int c0;
        @(negedge clk);
        c0 = cyc + 1;
        plan(from, goal, iv, c0, max_steps, 1'b1, tag, last, endc);
        target_code = 9'(t);
        target_load = 1'b1;
        zero_req    = z;
        @(negedge clk);
        target_load = 1'b0;
        zero_req    = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic check_now(input int code, input bit stl, input string tag);
        checks++;
        if (dac_code !== 9'(code) || settled !== stl) begin
            fails++;
            $display("FAIL %s: code=%0d settled=%0b, expected code=%0d settled=%0b",
                     tag, dac_code, settled, code, stl);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R1..R9 run incomplete): cycle=%0d, expected finish before 200000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c0, last, endc;
        repeat (3) @(negedge clk);
        check_now(0, 1'b0, "R1 reset");

        // Boot to 270 at soft-start pace; loads and boot_sel ignored meanwhile
        c0 = cyc;
        plan(0, 270, 16, c0, 1000, 1'b0, "R2 R1 boot", last, endc);
        rst = 1'b0;
        wait_until(c0 + 100);
        boot_sel    = 1'b0;
        target_code = 9'd40;
        target_load = 1'b1;
        @(negedge clk);
        target_load = 1'b0;
        wait_until(endc);

        slew_sel = 2'b00;
        go(101, 1'b0, 270, 101, 4, 1000, "R3 fast landing", last, endc);
        wait_until(endc);

        slew_sel = 2'b01; slow_sel = 2'b11;
        go(131, 1'b0, 101, 131, 64, 1000, "R4 slow x16", last, endc);
        wait_until(endc);

        slew_sel = 2'b10;
        go(140, 1'b0, 131, 140, 16, 1000, "R4 soft", last, endc);
        wait_until(endc);

        slew_sel = 2'b01; slow_sel = 2'b01;
        go(120, 1'b0, 140, 120, 8, 1000, "R4 slow x2", last, endc);
        wait_until(endc);

        slew_sel = 2'b00;
        go(200, 1'b0, 120, 200, 4, 3, "R7 first leg", last, endc);
        wait_until(endc);
        go(110, 1'b0, last, 110, 4, 1000, "R7 redirect", last, endc);
        wait_until(endc);

        go(500, 1'b0, 110, 460, 4, 1000, "R5 clamp", last, endc);
        wait_until(endc);

        slew_sel = 2'b01; slow_sel = 2'b00;
        go(300, 1'b1, 460, 0, 16, 1000, "R8 fault wins", last, endc);
        wait_until(endc);

        // Locked after fault
        @(negedge clk);
        c0 = cyc + 1;
        push(c0, 0, 1'b1, "R9 locked");
        push(c0 + 40, 0, 1'b1, "R9 locked");
        target_code = 9'd300;
        target_load = 1'b1;
        zero_req    = 1'b1;
        @(negedge clk);
        target_load = 1'b0;
        zero_req    = 1'b0;
        wait_until(c0 + 42);

        // Re-boot with the low boot goal
        rst = 1'b1;
        boot_sel = 1'b0;
        repeat (3) @(negedge clk);
        check_now(0, 1'b0, "R1 reset again");
        c0 = cyc;
        plan(0, 180, 16, c0, 1000, 1'b0, "R1 low boot", last, endc);
        rst = 1'b0;
        wait_until(endc);

        @(negedge clk);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R3: %0d expected items left, expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule